// File: doc/BRIEF.md
# Audio Clock Ratio Detector

This block runs in the audio master-clock domain. It measures how many master-clock cycles fit into one period of the frame (left/right) clock. From that count it decides which sampling-speed class the converters must use. The frame clock and the bit clock arrive asynchronously, so each passes through a synchronizer and an edge detector. One counter measures the frame period and a second counter totals the bit-clock rising edges in the same frame. The measured period is matched against the supported master-clock ratios with a small tolerance.

The speed class comes from one of two sources. In manual operation a two-bit selector picks the class. In automatic operation the class follows from the detected ratio and the selector is ignored. The block reports two flags that say whether the current ratio can be used in the chosen class: one for the playback path and a stricter one for the capture path.

After reset the block holds a power-down indication until it has measured one full frame. It raises a ready flag only after two consecutive measurements agree. If the frame clock stops, the block falls back to power-down. All results are registered and change only at a frame boundary.

Top module: `audio_clk_ratio_det`

## Requirements
- R1: While reset is asserted and afterwards until the first frame has been measured, pwr_down=1, ready=0, err=0, ratio_code=0, spd_mode=00, dac_ok=0 and adc_ok=0.
- R2: ratio_code encodes the measured master-clock cycles per frame as 1=128, 2=192, 3=256, 4=384, 5=512, 6=768. A count within ±2 cycles of a listed value maps to that code, and any other count gives 0.
- R3: With auto_sel=0, spd_mode follows spd_sel. The encoding is 00 normal, 01 double and 10 quad, and the value 11 is treated as normal (00).
- R4: With auto_sel=1, spd_sel has no effect. Codes 5 and 6 give spd_mode 00, codes 3 and 4 give 01, codes 1 and 2 give 10, and code 0 gives 00.
- R5: dac_ok=1 exactly when the code is allowed in spd_mode. In normal the allowed codes are 3, 4 and 5, in double they are 1, 2 and 3, and in quad only code 1 is allowed.
- R6: adc_ok=1 exactly when dac_ok=1 and either spd_mode is normal, or spd_mode is double and the code is 3.
- R7: The first frame-clock rising edge only arms the block. Each later edge completes a measurement and clears pwr_down. ready is set at a measurement only when the previous measurement exists, the two differ by at most 2 cycles, and the code is non-zero.
- R8: If 1024 master-clock cycles pass after an armed frame edge without another edge, every output returns to its reset value (pwr_down=1, ready=0). An edge that lands exactly on that cycle wins, and a period of 1024 is measured instead.
- R9: err is set at a measurement when the code is 0, or when the number of bit-clock rising edges in the frame differs from 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Audio master clock; clocks all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Frame clock, asynchronous to mclk |
| bick | input | 1 | Bit clock, asynchronous to mclk |
| auto_sel | input | 1 | 1 = automatic speed detection, 0 = manual |
| spd_sel | input | 2 | Manual speed class selector |
| spd_mode | output | 2 | Speed class in use (00 normal, 01 double, 10 quad) |
| ratio_code | output | 3 | Measured ratio code |
| dac_ok | output | 1 | Ratio usable by the playback path |
| adc_ok | output | 1 | Ratio usable by the capture path |
| ready | output | 1 | Ratio confirmed stable |
| pwr_down | output | 1 | Clocks absent or not yet measured |
| err | output | 1 | Unknown ratio or wrong bit-clock count |

## Verification
Two functions can fall in the same cycle: a frame edge arriving and the silence timeout expiring. The bench provokes this by driving a frame period of exactly 1024 master-clock cycles, so the detected edge lands on the cycle where the counter reaches its limit. It then expects a measurement of 1024, which gives code 0, err=1 and pwr_down=0, and not a power-down. A period of 1025 is driven as the contrast case and must give pwr_down=1 with ready=0.

// File: rtl/acrd_pkg.sv
package acrd_pkg;

  localparam logic [1:0] SPD_NORMAL = 2'b00;
  localparam logic [1:0] SPD_DOUBLE = 2'b01;
  localparam logic [1:0] SPD_QUAD   = 2'b10;

  typedef logic [2:0] ratio_code_t;

  localparam ratio_code_t RC_NONE = 3'd0;
  localparam ratio_code_t RC_128  = 3'd1;
  localparam ratio_code_t RC_192  = 3'd2;
  localparam ratio_code_t RC_256  = 3'd3;
  localparam ratio_code_t RC_384  = 3'd4;
  localparam ratio_code_t RC_512  = 3'd5;
  localparam ratio_code_t RC_768  = 3'd6;

  localparam int NUM_RATIOS = 6;

  // Odd codes are powers of two from 128 upward; even codes are 1.5x the code below.
  function automatic int unsigned nominal_of(input int unsigned code);
    int unsigned base;
    base = 128 << ((code - 1) / 2);
    if ((code % 2) == 0) nominal_of = (base * 3) / 2;
    else                 nominal_of = base;
  endfunction

endpackage

// File: rtl/acrd_sync.sv
module acrd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic rise
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              last_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise = sh_q[STAGES-1] & ~last_q;

  // A detected rising edge is a single-cycle pulse (feeds the R2 measurement).
  assert_rise_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/acrd_period_cnt.sv
module acrd_period_cnt #(
  parameter int TMO = 1024,
  parameter int CW  = 11,
  parameter int BW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_edge,
  input  logic          bick_edge,
  input  logic          armed,
  output logic [CW-1:0] meas,
  output logic [BW-1:0] bick_meas,
  output logic          tmo_hit
);

  localparam logic [CW-1:0] CNT_MAX  = CW'(TMO - 1);
  localparam logic [BW-1:0] BCNT_MAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic          cnt_en, bcnt_en;

  always_comb begin
    cnt_en = (cnt_q != CNT_MAX);
    if (frame_edge)  cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + CW'(1);
    else             cnt_d = cnt_q;
  end

  always_comb begin
    bcnt_en = bick_edge && (bcnt_q != BCNT_MAX);
    if (frame_edge)   bcnt_d = '0;
    else if (bcnt_en) bcnt_d = bcnt_q + BW'(1);
    else              bcnt_d = bcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_MAX;
      bcnt_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign meas      = cnt_q + CW'(1);
  assign bick_meas = bcnt_en ? bcnt_q + BW'(1) : bcnt_q;
  assign tmo_hit   = armed && !frame_edge && (cnt_q == CNT_MAX);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  assert_cnt_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_edge |=> (cnt_q == '0));

endmodule

// File: rtl/acrd_classify.sv
module acrd_classify
  import acrd_pkg::*;
#(
  parameter int CW  = 11,
  parameter int TOL = 2
) (
  input  logic [CW-1:0] meas,
  input  logic          auto_sel,
  input  logic [1:0]    spd_sel,
  output ratio_code_t   code,
  output logic [1:0]    mode,
  output logic          known,
  output logic          dac_ok,
  output logic          adc_ok
);

  logic [NUM_RATIOS-1:0] hit;

  for (genvar gi = 0; gi < NUM_RATIOS; gi++) begin : g_win
    localparam int unsigned   NOM = nominal_of(gi + 1);
    localparam logic [CW-1:0] LO  = CW'(NOM - TOL);
    localparam logic [CW-1:0] HI  = CW'(NOM + TOL);
    assign hit[gi] = (meas >= LO) && (meas <= HI);
  end

  always_comb begin
    code = RC_NONE;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (hit[i]) code = ratio_code_t'(i + 1);
    end
  end

  assign known = (code != RC_NONE);

  always_comb begin
    if (auto_sel) begin
      unique case (code)
        RC_512, RC_768: mode = SPD_NORMAL;
        RC_256, RC_384: mode = SPD_DOUBLE;
        RC_128, RC_192: mode = SPD_QUAD;
        default:        mode = SPD_NORMAL;
      endcase
    end else if (spd_sel == 2'b11) begin
      mode = SPD_NORMAL;
    end else begin
      mode = spd_sel;
    end
  end

  always_comb begin
    unique case (mode)
      SPD_NORMAL: dac_ok = (code == RC_256) || (code == RC_384) || (code == RC_512);
      SPD_DOUBLE: dac_ok = (code == RC_128) || (code == RC_192) || (code == RC_256);
      SPD_QUAD:   dac_ok = (code == RC_128);
      default:    dac_ok = 1'b0;
    endcase
  end

  assign adc_ok = dac_ok && ((mode == SPD_NORMAL) ||
                             ((mode == SPD_DOUBLE) && (code == RC_256)));

  always_comb begin
    assert_hit_onehot_R2: assert ($onehot0(hit));
    assert_quad_never_adc_R6: assert (!(adc_ok && (mode == SPD_QUAD)));
  end

endmodule

// File: rtl/audio_clk_ratio_det.sv
module audio_clk_ratio_det
  import acrd_pkg::*;
#(
  parameter int TMO            = 1024,
  parameter int TOL            = 2,
  parameter int BICK_PER_FRAME = 64,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       lrck,
  input  logic       bick,
  input  logic       auto_sel,
  input  logic [1:0] spd_sel,
  output logic [1:0] spd_mode,
  output logic [2:0] ratio_code,
  output logic       dac_ok,
  output logic       adc_ok,
  output logic       ready,
  output logic       pwr_down,
  output logic       err
);

  localparam int CW = $clog2(TMO) + 1;
  localparam int BW = $clog2(BICK_PER_FRAME) + 2;
  localparam logic [BW-1:0] BICK_EXP = BW'(BICK_PER_FRAME);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic          lr_rise, bk_rise, tmo_hit;
  logic [CW-1:0] meas;
  logic [BW-1:0] bick_meas;
  ratio_code_t   cls_code;
  logic [1:0]    cls_mode;
  logic          cls_known, cls_dac, cls_adc;

  acrd_sync #(.STAGES(SYNC_STAGES)) u_lr_sync (
    .clk(mclk), .rst_n(rst_sync_n), .d_async(lrck), .rise(lr_rise)
  );

  acrd_sync #(.STAGES(SYNC_STAGES)) u_bk_sync (
    .clk(mclk), .rst_n(rst_sync_n), .d_async(bick), .rise(bk_rise)
  );

  logic armed_q, armed_d;

  acrd_period_cnt #(.TMO(TMO), .CW(CW), .BW(BW)) u_cnt (
    .clk(mclk), .rst_n(rst_sync_n), .frame_edge(lr_rise), .bick_edge(bk_rise),
    .armed(armed_q), .meas(meas), .bick_meas(bick_meas), .tmo_hit(tmo_hit)
  );

  acrd_classify #(.CW(CW), .TOL(TOL)) u_cls (
    .meas(meas), .auto_sel(auto_sel), .spd_sel(spd_sel), .code(cls_code),
    .mode(cls_mode), .known(cls_known), .dac_ok(cls_dac), .adc_ok(cls_adc)
  );

  // Agreement with the previous measurement.
  logic [CW-1:0] prev_q, prev_d, diff;
  logic          close;
  assign diff  = (meas >= prev_q) ? (meas - prev_q) : (prev_q - meas);
  assign close = (diff <= CW'(TOL));

  logic        have_prev_q, have_prev_d;
  logic        pwr_q, pwr_d, ready_q, ready_d, err_q, err_d;
  logic        dac_q, dac_d, adc_q, adc_d;
  ratio_code_t code_q, code_d;
  logic [1:0]  mode_q, mode_d;

  always_comb begin
    armed_d     = armed_q;
    have_prev_d = have_prev_q;
    prev_d      = prev_q;
    pwr_d       = pwr_q;
    ready_d     = ready_q;
    err_d       = err_q;
    code_d      = code_q;
    mode_d      = mode_q;
    dac_d       = dac_q;
    adc_d       = adc_q;
    if (tmo_hit) begin
      armed_d     = 1'b0;
      have_prev_d = 1'b0;
      pwr_d       = 1'b1;
      ready_d     = 1'b0;
      err_d       = 1'b0;
      code_d      = RC_NONE;
      mode_d      = SPD_NORMAL;
      dac_d       = 1'b0;
      adc_d       = 1'b0;
    end else if (lr_rise) begin
      if (!armed_q) begin
        armed_d = 1'b1;
      end else begin
        pwr_d       = 1'b0;
        code_d      = cls_code;
        mode_d      = cls_mode;
        dac_d       = cls_dac;
        adc_d       = cls_adc;
        err_d       = !cls_known || (bick_meas != BICK_EXP);
        ready_d     = have_prev_q && cls_known && close;
        prev_d      = meas;
        have_prev_d = 1'b1;
      end
    end
  end

  always_ff @(posedge mclk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      armed_q     <= 1'b0;
      have_prev_q <= 1'b0;
      prev_q      <= '0;
      pwr_q       <= 1'b1;
      ready_q     <= 1'b0;
      err_q       <= 1'b0;
      code_q      <= RC_NONE;
      mode_q      <= SPD_NORMAL;
      dac_q       <= 1'b0;
      adc_q       <= 1'b0;
    end else begin
      armed_q     <= armed_d;
      have_prev_q <= have_prev_d;
      prev_q      <= prev_d;
      pwr_q       <= pwr_d;
      ready_q     <= ready_d;
      err_q       <= err_d;
      code_q      <= code_d;
      mode_q      <= mode_d;
      dac_q       <= dac_d;
      adc_q       <= adc_d;
    end
  end

  assign spd_mode   = mode_q;
  assign ratio_code = code_q;
  assign dac_ok     = dac_q;
  assign adc_ok     = adc_q;
  assign ready      = ready_q;
  assign pwr_down   = pwr_q;
  assign err        = err_q;

  assert_ready_powered_R7: assert property (@(posedge mclk) disable iff (!rst_sync_n)
    ready_q |-> !pwr_q);

  assert_ready_known_R7: assert property (@(posedge mclk) disable iff (!rst_sync_n)
    ready_q |-> (code_q != RC_NONE));

  assert_timeout_drop_R8: assert property (@(posedge mclk) disable iff (!rst_sync_n)
    tmo_hit |=> (pwr_q && !ready_q && !armed_q));

  assert_manual_mode_R3: assert property (@(posedge mclk) disable iff (!rst_sync_n)
    (lr_rise && armed_q && !auto_sel && (spd_sel != 2'b11)) |=> (mode_q == $past(spd_sel)));

  assert_power_stays_R1: assert property (@(posedge mclk) disable iff (!rst_sync_n)
    (pwr_q && !lr_rise) |=> pwr_q);

endmodule

// File: tb/audio_clk_ratio_det_test.sv
module audio_clk_ratio_det_test;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lrck = 1'b0;
  logic       bick = 1'b0;
  logic       auto_sel = 1'b0;
  logic [1:0] spd_sel = 2'b00;
  logic [1:0] spd_mode;
  logic [2:0] ratio_code;
  logic       dac_ok, adc_ok, ready, pwr_down, err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 mclk = ~mclk;

  audio_clk_ratio_det uut (
    .mclk(mclk), .rst_n(rst_n), .lrck(lrck), .bick(bick), .auto_sel(auto_sel),
    .spd_sel(spd_sel), .spd_mode(spd_mode), .ratio_code(ratio_code),
    .dac_ok(dac_ok), .adc_ok(adc_ok), .ready(ready), .pwr_down(pwr_down), .err(err)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int nom(input int c);
    case (c)
      1: nom = 128; 2: nom = 192; 3: nom = 256;
      4: nom = 384; 5: nom = 512; 6: nom = 768;
      default: nom = 0;
    endcase
  endfunction

  function automatic int exp_code(input int n);
    exp_code = 0;
    for (int c = 1; c <= 6; c++) begin
      if (n >= nom(c) - 2 && n <= nom(c) + 2) exp_code = c;
    end
  endfunction

  function automatic int exp_mode(input bit a, input int sel, input int c);
    if (a) begin
      if (c == 5 || c == 6)      exp_mode = 0;
      else if (c == 3 || c == 4) exp_mode = 1;
      else if (c == 1 || c == 2) exp_mode = 2;
      else                       exp_mode = 0;
    end else begin
      exp_mode = (sel == 3) ? 0 : sel;
    end
  endfunction

  function automatic int exp_dac(input int m, input int c);
    if (m == 0)      exp_dac = (c >= 3 && c <= 5) ? 1 : 0;
    else if (m == 1) exp_dac = (c >= 1 && c <= 3) ? 1 : 0;
    else if (m == 2) exp_dac = (c == 1) ? 1 : 0;
    else             exp_dac = 0;
  endfunction

  // Drive n master cycles per frame; bit clock has period p, low at the frame start.
  task automatic run_frames(input int n, input int p, input int frames);
    for (int f = 0; f < frames; f++) begin
      for (int k = 0; k < n; k++) begin
        @(negedge mclk);
        lrck = (k < n / 2);
        bick = ((k % p) >= (p / 2));
      end
    end
  endtask

  task automatic scen(input string mtag, input int n, input int p, input bit a,
                      input int sel, input bit bick_bad);
    int c, m, d, ad;
    auto_sel = a;
    spd_sel  = 2'(sel);
    run_frames(n, p, 4);
    @(negedge mclk);
    c  = exp_code(n);
    m  = exp_mode(a, sel, c);
    d  = exp_dac(m, c);
    ad = (d == 1 && (m == 0 || (m == 1 && c == 3))) ? 1 : 0;
    chk("R2", $sformatf("ratio_code n=%0d", n), ratio_code, c);
    chk(mtag, $sformatf("spd_mode n=%0d sel=%0d auto=%0d", n, sel, a), spd_mode, m);
    chk("R5", $sformatf("dac_ok n=%0d mode=%0d", n, m), dac_ok, d);
    chk("R6", $sformatf("adc_ok n=%0d mode=%0d", n, m), adc_ok, ad);
    chk("R7", $sformatf("ready n=%0d", n), ready, (c != 0) ? 1 : 0);
    chk("R7", $sformatf("pwr_down n=%0d", n), pwr_down, 0);
    chk("R9", $sformatf("err n=%0d", n), err, (c == 0 || bick_bad) ? 1 : 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge mclk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge mclk);
    chk("R1", "pwr_down in reset", pwr_down, 1);
    chk("R1", "ready in reset", ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge mclk);
    chk("R1", "pwr_down after reset", pwr_down, 1);
    chk("R1", "ready after reset", ready, 0);
    chk("R1", "err after reset", err, 0);
    chk("R1", "ratio_code after reset", ratio_code, 0);
    chk("R1", "spd_mode after reset", spd_mode, 0);
    chk("R1", "dac_ok after reset", dac_ok, 0);
    chk("R1", "adc_ok after reset", adc_ok, 0);
    repeat (50) @(negedge mclk);
    chk("R7", "pwr_down without frame clock", pwr_down, 1);

    // Manual sweep: every selector value against every supported ratio.
    for (int s = 0; s < 4; s++) begin
      for (int c = 1; c <= 6; c++) begin
        scen("R3", nom(c), nom(c) / 64, 1'b0, s, 1'b0);
      end
    end

    // Automatic sweep with the selector parked on quad to show it is ignored.
    for (int c = 1; c <= 6; c++) begin
      scen("R4", nom(c), nom(c) / 64, 1'b1, 2, 1'b0);
    end

    // Tolerance edges around 256 and an unknown period.
    scen("R4", 257, 4, 1'b1, 0, 1'b0);
    scen("R4", 258, 4, 1'b1, 0, 1'b0);
    scen("R4", 254, 4, 1'b1, 0, 1'b1);  // 63 bit-clock edges: R9
    scen("R4", 300, 4, 1'b1, 0, 1'b1);

    // Correct ratio but only 32 bit-clock edges per frame: R9.
    scen("R3", 256, 8, 1'b0, 0, 1'b1);

    // R8 coincidence: the edge lands on the timeout cycle and is measured.
    scen("R4", 1024, 16, 1'b1, 0, 1'b1);

    // R8 timeout: one cycle longer than the limit.
    run_frames(1025, 16, 3);
    @(negedge mclk);
    chk("R8", "pwr_down after silence", pwr_down, 1);
    chk("R8", "ready after silence", ready, 0);
    chk("R8", "ratio_code after silence", ratio_code, 0);

    // R7 recovery: arm, first measurement, then confirmation.
    auto_sel = 1'b1;
    run_frames(512, 8, 2);
    @(negedge mclk);
    chk("R7", "pwr_down after first measurement", pwr_down, 0);
    chk("R7", "ready after first measurement", ready, 0);
    run_frames(512, 8, 1);
    @(negedge mclk);
    chk("R7", "ready after second measurement", ready, 1);
    chk("R4", "spd_mode after recovery", spd_mode, 0);

    finish_run();
  end

endmodule